// File: doc/BRIEF.md
# I2C Controller Status and Event Capture Unit

This block collects the protocol events reported by an I2C-compatible bus engine and turns them into an 8-bit status word for the host. The bus engine does the bit shifting, clock generation and address comparison. It sends single-cycle strobes to this block for the following events:

- start and stop conditions, together with the current bit index inside the byte;
- acknowledge samples;
- own-address and general-call matches;
- arbitration loss;
- master grant;
- completion of the address phase.

The engine also drives a level that gives the transfer direction. The block captures each event in a flag and clears each flag by its own rule.

The host reads the status word. It clears the sticky event flags by writing ones to them. Its reads and writes of the data register clear the data-ready flag. An interrupt output combines the event flags with the interrupt enable. A hold output asks the engine to keep SCL low while the stall-after-start flag is set. When the controller enable is low, the whole word stays at zero and incoming events are dropped.

Top module: `i2c_stat_evt`

## Requirements
- R1: After reset, status reads 8'h00 and irq and scl_hold are 0.
- R2: While ctl_en is 0, status is 8'h00 on the next cycle and stays there, and bus events arriving in that time set nothing.
- R3: Bits 7 (slave-stop), 5 (bus-error), 4 (negative-ack), 3 (stall-after-start) and 2 (new-match) clear when host_stat_wr writes a 1 to their position. Writing 0 leaves them unchanged. Writes have no effect on bits 6 (data-ready), 1 (master-active) and 0 (transmit).
- R4: Bit 7 sets on a stop that ends a slave session, that is, a stop after an own-address or general-call match seen while not master. A stop with no prior match leaves it at 0.
- R5: Bit 6 sets on an acknowledge sample of a received byte, or of a transmitted byte that was acknowledged. It clears on host_data_wr while bit 0 is 1, or on host_data_rd while bit 0 is 0.
- R6: host_data_rd leaves bit 6 at 1 while ctl_start_req is 1.
- R7: Bit 5 sets when a start or stop arrives with bus_bit_idx from 2 to 9 (9 is the acknowledge slot), and also on arbitration loss. A start or stop at index 0 or 1 leaves it at 0.
- R8: An acknowledge sample of a transmitted byte with bus_ack_nack=1 sets bit 4 and does not set bit 6.
- R9: Bit 3 sets when bus_addr_done arrives while bit 1 is 1, ctl_stall_en is 1 and no bus error occurs in that cycle. scl_hold is 1 exactly while bit 3 is 1.
- R10: Bit 2 sets on bus_own_match or bus_gc_match.
- R11: Bit 1 sets on bus_mst_grant and clears on arbitration loss or on a stop; clearing wins. Bit 0 follows bus_xmit one cycle later.
- R12: irq is ctl_irq_en AND the OR of bits 7, 6, 5, 4, 3 and 2. It is a level and falls once those bits are clear.
- R13: When a set event and a write-one-clear hit the same bit in the same cycle, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_en | input | 1 | Controller enable |
| ctl_irq_en | input | 1 | Interrupt enable |
| ctl_stall_en | input | 1 | Stall-after-start enable |
| ctl_start_req | input | 1 | Start request pending |
| host_stat_wr | input | 1 | Host write strobe to the status word |
| host_wdata | input | 8 | Host write data, one bit per status position |
| host_data_rd | input | 1 | Host read strobe of the data register |
| host_data_wr | input | 1 | Host write strobe of the data register |
| bus_start | input | 1 | Start condition detected |
| bus_stop | input | 1 | Stop condition detected |
| bus_bit_idx | input | IDX_W | Bit index in the byte: 0 between bytes, 1..8 data bits, 9 acknowledge slot |
| bus_ack_stb | input | 1 | Acknowledge sample strobe |
| bus_ack_nack | input | 1 | Sampled acknowledge level, 1 means not acknowledged |
| bus_byte_tx | input | 1 | The sampled byte was transmitted by this controller |
| bus_addr_done | input | 1 | Master address phase complete |
| bus_own_match | input | 1 | Own-address match after a start |
| bus_gc_match | input | 1 | General-call match after a start |
| bus_arb_lost | input | 1 | Arbitration loss |
| bus_mst_grant | input | 1 | Master request granted |
| bus_xmit | input | 1 | Transmit direction level |
| status | output | 8 | Status word |
| irq | output | 1 | Interrupt request, level |
| scl_hold | output | 1 | Request to hold SCL low |

## Verification
The bench uses the default parameters: a 4-bit bit index, an error window starting at index 2, and the acknowledge slot at index 9. With these values it can reach both edges of the error window (indices 1 and 2, and index 9 against index 0) using directed index values. It also reaches the cases where two rules compete in one cycle: set against clear on a bit, stop against grant, and a data read made with a pending start request.

// File: rtl/i2c_stat_pkg.sv
package i2c_stat_pkg;

  localparam int STAT_W = 8;

  typedef struct packed {
    logic slv_stop;   // 7
    logic data_rdy;   // 6
    logic bus_err;    // 5
    logic nack;       // 4
    logic stall;      // 3
    logic new_match;  // 2
    logic mst_act;    // 1
    logic xmit;       // 0
  } stat_t;

  localparam logic [STAT_W-1:0] W1C_MASK = 8'b1011_1100;

  function automatic logic in_err_window(input int unsigned idx,
                                         input int unsigned lo,
                                         input int unsigned hi);
    return (idx >= lo) && (idx <= hi);
  endfunction

  function automatic logic irq_level(input stat_t s, input logic en);
    return en & (s.slv_stop | s.data_rdy | s.bus_err |
                 s.nack | s.stall | s.new_match);
  endfunction

endpackage

// File: rtl/i2c_stat_dec.sv
module i2c_stat_dec
  import i2c_stat_pkg::*;
#(
  parameter int IDX_W    = 4,
  parameter int ERR_LO   = 2,
  parameter int ACK_SLOT = 9
) (
  input  logic             ctl_stall_en,
  input  logic             mst_act_q,
  input  logic             slv_sess_q,
  input  logic             bus_start,
  input  logic             bus_stop,
  input  logic [IDX_W-1:0] bus_bit_idx,
  input  logic             bus_ack_stb,
  input  logic             bus_ack_nack,
  input  logic             bus_byte_tx,
  input  logic             bus_addr_done,
  input  logic             bus_own_match,
  input  logic             bus_gc_match,
  input  logic             bus_arb_lost,
  input  logic             bus_mst_grant,
  output logic             set_slv_stop,
  output logic             set_data_rdy,
  output logic             set_bus_err,
  output logic             set_nack,
  output logic             set_stall,
  output logic             set_new_match,
  output logic             set_mst,
  output logic             clr_mst,
  output logic             sess_open
);

  logic cond_seen;
  logic in_window;
  logic any_match;

  assign cond_seen = bus_start | bus_stop;
  assign in_window = in_err_window(int'(unsigned'(bus_bit_idx)), ERR_LO, ACK_SLOT);
  assign any_match = bus_own_match | bus_gc_match;

  assign set_bus_err   = bus_arb_lost | (cond_seen & in_window);
  assign set_nack      = bus_ack_stb & bus_byte_tx & bus_ack_nack;
  assign set_data_rdy  = bus_ack_stb & ~(bus_byte_tx & bus_ack_nack);
  assign set_new_match = any_match;
  assign set_slv_stop  = bus_stop & slv_sess_q;
  assign set_stall     = bus_addr_done & mst_act_q & ctl_stall_en & ~set_bus_err;
  assign set_mst       = bus_mst_grant;
  assign clr_mst       = bus_arb_lost | bus_stop;
  assign sess_open     = any_match & ~mst_act_q;

endmodule

// File: rtl/i2c_stat_flags.sv
module i2c_stat_flags
  import i2c_stat_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_en,
  input  logic              ctl_stall_en,
  input  logic              ctl_start_req,
  input  logic              host_stat_wr,
  input  logic [STAT_W-1:0] host_wdata,
  input  logic              host_data_rd,
  input  logic              host_data_wr,
  input  logic              bus_stop,
  input  logic              bus_xmit,
  input  logic              set_slv_stop,
  input  logic              set_data_rdy,
  input  logic              set_bus_err,
  input  logic              set_nack,
  input  logic              set_stall,
  input  logic              set_new_match,
  input  logic              set_mst,
  input  logic              clr_mst,
  input  logic              sess_open,
  output stat_t             stat_q,
  output logic              slv_sess_q
);

  stat_t nxt;
  logic  sess_nxt;
  logic  rdy_taken;
  logic [STAT_W-1:0] wclr;

  assign wclr      = host_stat_wr ? (host_wdata & W1C_MASK) : '0;
  assign rdy_taken = (host_data_wr & stat_q.xmit) |
                     (host_data_rd & ~stat_q.xmit & ~ctl_start_req);

  always_comb begin
    nxt = stat_q;
    // clears first, sets afterwards so a coincident event is kept
    if (wclr[7]) nxt.slv_stop  = 1'b0;
    if (wclr[5]) nxt.bus_err   = 1'b0;
    if (wclr[4]) nxt.nack      = 1'b0;
    if (wclr[3]) nxt.stall     = 1'b0;
    if (wclr[2]) nxt.new_match = 1'b0;
    if (rdy_taken) nxt.data_rdy = 1'b0;
    if (set_slv_stop)  nxt.slv_stop  = 1'b1;
    if (set_data_rdy)  nxt.data_rdy  = 1'b1;
    if (set_bus_err)   nxt.bus_err   = 1'b1;
    if (set_nack)      nxt.nack      = 1'b1;
    if (set_stall)     nxt.stall     = 1'b1;
    if (set_new_match) nxt.new_match = 1'b1;
    if (clr_mst)       nxt.mst_act   = 1'b0;
    else if (set_mst)  nxt.mst_act   = 1'b1;
    nxt.xmit = bus_xmit;
    if (!ctl_en) nxt = '0;
  end

  always_comb begin
    sess_nxt = slv_sess_q;
    if (sess_open) sess_nxt = 1'b1;
    if (bus_stop)  sess_nxt = 1'b0;
    if (!ctl_en)   sess_nxt = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q     <= '0;
      slv_sess_q <= 1'b0;
    end else begin
      stat_q     <= nxt;
      slv_sess_q <= sess_nxt;
    end
  end

  a_r2_disabled_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_en |=> (stat_q == '0));

  a_r3_zero_write_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_en && host_stat_wr && !host_wdata[5] && stat_q.bus_err |=> stat_q.bus_err);

  a_r6_start_req_keeps_ready: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_en && host_data_rd && !host_data_wr && ctl_start_req && stat_q.data_rdy
    |=> stat_q.data_rdy);

  a_r8_nack_blocks_ready: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_en && set_nack && !stat_q.data_rdy |=> !stat_q.data_rdy);

  a_r9_stall_needs_master: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_q.stall) |-> $past(stat_q.mst_act && ctl_stall_en));

  a_r13_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_en && set_new_match && host_stat_wr && host_wdata[2] |=> stat_q.new_match);

endmodule

// File: rtl/i2c_stat_out.sv
module i2c_stat_out
  import i2c_stat_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  ctl_irq_en,
  input  stat_t stat_q,
  output logic  irq,
  output logic  scl_hold
);

  assign irq      = irq_level(stat_q, ctl_irq_en);
  assign scl_hold = stat_q.stall;

  a_r12_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_irq_en |-> !irq);

  a_r12_stall_raises_irq: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_irq_en && scl_hold |-> irq);

endmodule

// File: rtl/i2c_stat_evt.sv
module i2c_stat_evt
  import i2c_stat_pkg::*;
#(
  parameter int IDX_W    = 4,
  parameter int ERR_LO   = 2,
  parameter int ACK_SLOT = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_en,
  input  logic              ctl_irq_en,
  input  logic              ctl_stall_en,
  input  logic              ctl_start_req,
  input  logic              host_stat_wr,
  input  logic [STAT_W-1:0] host_wdata,
  input  logic              host_data_rd,
  input  logic              host_data_wr,
  input  logic              bus_start,
  input  logic              bus_stop,
  input  logic [IDX_W-1:0]  bus_bit_idx,
  input  logic              bus_ack_stb,
  input  logic              bus_ack_nack,
  input  logic              bus_byte_tx,
  input  logic              bus_addr_done,
  input  logic              bus_own_match,
  input  logic              bus_gc_match,
  input  logic              bus_arb_lost,
  input  logic              bus_mst_grant,
  input  logic              bus_xmit,
  output logic [STAT_W-1:0] status,
  output logic              irq,
  output logic              scl_hold
);

  stat_t stat_q;
  logic  slv_sess_q;
  logic  set_slv_stop, set_data_rdy, set_bus_err, set_nack;
  logic  set_stall, set_new_match, set_mst, clr_mst, sess_open;

  i2c_stat_dec #(.IDX_W(IDX_W), .ERR_LO(ERR_LO), .ACK_SLOT(ACK_SLOT)) u_dec (
    .ctl_stall_en (ctl_stall_en),
    .mst_act_q    (stat_q.mst_act),
    .slv_sess_q   (slv_sess_q),
    .bus_start    (bus_start),
    .bus_stop     (bus_stop),
    .bus_bit_idx  (bus_bit_idx),
    .bus_ack_stb  (bus_ack_stb),
    .bus_ack_nack (bus_ack_nack),
    .bus_byte_tx  (bus_byte_tx),
    .bus_addr_done(bus_addr_done),
    .bus_own_match(bus_own_match),
    .bus_gc_match (bus_gc_match),
    .bus_arb_lost (bus_arb_lost),
    .bus_mst_grant(bus_mst_grant),
    .set_slv_stop (set_slv_stop),
    .set_data_rdy (set_data_rdy),
    .set_bus_err  (set_bus_err),
    .set_nack     (set_nack),
    .set_stall    (set_stall),
    .set_new_match(set_new_match),
    .set_mst      (set_mst),
    .clr_mst      (clr_mst),
    .sess_open    (sess_open)
  );

  i2c_stat_flags u_flags (
    .clk          (clk),
    .rst_n        (rst_n),
    .ctl_en       (ctl_en),
    .ctl_stall_en (ctl_stall_en),
    .ctl_start_req(ctl_start_req),
    .host_stat_wr (host_stat_wr),
    .host_wdata   (host_wdata),
    .host_data_rd (host_data_rd),
    .host_data_wr (host_data_wr),
    .bus_stop     (bus_stop),
    .bus_xmit     (bus_xmit),
    .set_slv_stop (set_slv_stop),
    .set_data_rdy (set_data_rdy),
    .set_bus_err  (set_bus_err),
    .set_nack     (set_nack),
    .set_stall    (set_stall),
    .set_new_match(set_new_match),
    .set_mst      (set_mst),
    .clr_mst      (clr_mst),
    .sess_open    (sess_open),
    .stat_q       (stat_q),
    .slv_sess_q   (slv_sess_q)
  );

  i2c_stat_out u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctl_irq_en(ctl_irq_en),
    .stat_q    (stat_q),
    .irq       (irq),
    .scl_hold  (scl_hold)
  );

  assign status = stat_q;

endmodule

// File: tb/test_i2c_stat_evt.sv
module test_i2c_stat_evt;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ctl_en = 1'b0, ctl_irq_en = 1'b0, ctl_stall_en = 1'b0, ctl_start_req = 1'b0;
  logic host_stat_wr = 1'b0, host_data_rd = 1'b0, host_data_wr = 1'b0;
  logic [7:0] host_wdata = 8'h00;
  logic bus_start = 1'b0, bus_stop = 1'b0, bus_ack_stb = 1'b0, bus_ack_nack = 1'b0;
  logic bus_byte_tx = 1'b0, bus_addr_done = 1'b0, bus_own_match = 1'b0, bus_gc_match = 1'b0;
  logic bus_arb_lost = 1'b0, bus_mst_grant = 1'b0, bus_xmit = 1'b0;
  logic [3:0] bus_bit_idx = 4'd0;
  logic [7:0] status;
  logic irq, scl_hold;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  i2c_stat_evt i_i2c_stat_evt (
    .clk(clk), .rst_n(rst_n), .ctl_en(ctl_en), .ctl_irq_en(ctl_irq_en),
    .ctl_stall_en(ctl_stall_en), .ctl_start_req(ctl_start_req),
    .host_stat_wr(host_stat_wr), .host_wdata(host_wdata),
    .host_data_rd(host_data_rd), .host_data_wr(host_data_wr),
    .bus_start(bus_start), .bus_stop(bus_stop), .bus_bit_idx(bus_bit_idx),
    .bus_ack_stb(bus_ack_stb), .bus_ack_nack(bus_ack_nack), .bus_byte_tx(bus_byte_tx),
    .bus_addr_done(bus_addr_done), .bus_own_match(bus_own_match),
    .bus_gc_match(bus_gc_match), .bus_arb_lost(bus_arb_lost),
    .bus_mst_grant(bus_mst_grant), .bus_xmit(bus_xmit),
    .status(status), .irq(irq), .scl_hold(scl_hold)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one clock: inputs set before the call are captured, strobes dropped after
  task automatic tick();
    @(negedge clk);
    host_stat_wr = 0; host_wdata = 0; host_data_rd = 0; host_data_wr = 0;
    bus_start = 0; bus_stop = 0; bus_ack_stb = 0; bus_ack_nack = 0; bus_byte_tx = 0;
    bus_addr_done = 0; bus_own_match = 0; bus_gc_match = 0; bus_arb_lost = 0;
    bus_mst_grant = 0; bus_bit_idx = 0;
  endtask

  task automatic clear_all();
    host_stat_wr = 1; host_wdata = 8'hFF; tick();
  endtask

  task automatic t_reset();
    chk("R1 status", status, 8'h00);
    chk("R1 irq/hold", {6'd0, irq, scl_hold}, 8'h00);
  endtask

  task automatic t_disable();
    bus_arb_lost = 1; tick();
    chk("R7 arb loss", status & 8'h20, 8'h20);
    ctl_en = 0; tick();
    chk("R2 cleared", status, 8'h00);
    bus_own_match = 1; bus_xmit = 1; bus_mst_grant = 1; tick();
    chk("R2 events ignored", status, 8'h00);
    bus_xmit = 0; ctl_en = 1; tick();
  endtask

  task automatic t_w1c();
    bus_arb_lost = 1; tick();
    host_stat_wr = 1; host_wdata = 8'h00; tick();
    chk("R3 zero write", status & 8'h20, 8'h20);
    host_stat_wr = 1; host_wdata = 8'h20; tick();
    chk("R3 one write", status & 8'h20, 8'h00);
    bus_mst_grant = 1; bus_xmit = 1; tick();
    bus_ack_stb = 1; tick();
    host_stat_wr = 1; host_wdata = 8'hFF; tick();
    chk("R3 RO bits kept", status, 8'h43);
    host_data_wr = 1; bus_stop = 1; bus_xmit = 0; tick();
    clear_all();
    chk("R3 all clear", status, 8'h00);
  endtask

  task automatic t_err_window();
    bus_start = 1; bus_bit_idx = 4'd1; tick();
    chk("R7 idx1 start", status & 8'h20, 8'h00);
    bus_start = 1; bus_bit_idx = 4'd2; tick();
    chk("R7 idx2 start", status & 8'h20, 8'h20);
    clear_all();
    bus_stop = 1; bus_bit_idx = 4'd9; tick();
    chk("R7 ack slot stop", status & 8'h20, 8'h20);
    clear_all();
    bus_stop = 1; bus_bit_idx = 4'd0; tick();
    chk("R7 idx0 stop", status & 8'h20, 8'h00);
  endtask

  task automatic t_master();
    bus_mst_grant = 1; tick();
    chk("R11 grant", status & 8'h02, 8'h02);
    bus_stop = 1; tick();
    chk("R11 stop clears", status & 8'h02, 8'h00);
    bus_mst_grant = 1; bus_stop = 1; tick();
    chk("R11 clear wins", status & 8'h02, 8'h00);
    bus_mst_grant = 1; tick();
    bus_arb_lost = 1; tick();
    chk("R11 arb loss", status & 8'h22, 8'h20);
    bus_xmit = 1; tick();
    chk("R11 xmit", status & 8'h01, 8'h01);
    bus_xmit = 0; tick();
    chk("R11 xmit off", status & 8'h01, 8'h00);
    clear_all();
  endtask

  task automatic t_tx_data();
    bus_xmit = 1; tick();
    bus_ack_stb = 1; bus_byte_tx = 1; bus_ack_nack = 1; tick();
    chk("R8 nack", status & 8'h50, 8'h10);
    bus_ack_stb = 1; bus_byte_tx = 1; tick();
    chk("R5 tx ready", status & 8'h40, 8'h40);
    host_data_rd = 1; tick();
    chk("R5 read in tx keeps", status & 8'h40, 8'h40);
    host_data_wr = 1; tick();
    chk("R5 write clears", status & 8'h40, 8'h00);
    bus_xmit = 0; clear_all();
  endtask

  task automatic t_rx_data();
    bus_ack_stb = 1; tick();
    chk("R5 rx ready", status & 8'h40, 8'h40);
    ctl_start_req = 1; host_data_rd = 1; tick();
    chk("R6 start req keeps", status & 8'h40, 8'h40);
    ctl_start_req = 0; host_data_rd = 1; tick();
    chk("R5 read clears", status & 8'h40, 8'h00);
  endtask

  task automatic t_stall();
    ctl_stall_en = 1; bus_addr_done = 1; tick();
    chk("R9 not master", {status[3], scl_hold}, 8'h00);
    bus_mst_grant = 1; tick();
    ctl_stall_en = 0; bus_addr_done = 1; tick();
    chk("R9 enable off", status & 8'h08, 8'h00);
    ctl_stall_en = 1; bus_addr_done = 1; bus_start = 1; bus_bit_idx = 4'd5; tick();
    chk("R9 error blocks", status & 8'h28, 8'h20);
    clear_all();
    bus_addr_done = 1; tick();
    chk("R9 stall", {status[3], scl_hold}, 8'h03);
    host_stat_wr = 1; host_wdata = 8'h08; tick();
    chk("R9 hold released", {status[3], scl_hold}, 8'h00);
    ctl_stall_en = 0; bus_stop = 1; tick();
    clear_all();
  endtask

  task automatic t_slave();
    bus_stop = 1; tick();
    chk("R4 stop no match", status & 8'h80, 8'h00);
    bus_own_match = 1; tick();
    chk("R10 own match", status & 8'h04, 8'h04);
    bus_stop = 1; tick();
    chk("R4 slave stop", status & 8'h80, 8'h80);
    clear_all();
    bus_gc_match = 1; tick();
    chk("R10 gc match", status & 8'h04, 8'h04);
    bus_stop = 1; tick();
    chk("R4 gc session stop", status & 8'h80, 8'h80);
    clear_all();
  endtask

  task automatic t_irq();
    ctl_irq_en = 1; tick();
    chk("R12 idle", {7'd0, irq}, 8'h00);
    bus_own_match = 1; tick();
    chk("R12 raised", {7'd0, irq}, 8'h01);
    ctl_irq_en = 0; tick();
    chk("R12 masked", {7'd0, irq}, 8'h00);
    ctl_irq_en = 1; bus_stop = 1; tick();
    clear_all();
    chk("R12 dropped", {7'd0, irq}, 8'h00);
    ctl_irq_en = 0;
  endtask

  task automatic t_set_wins();
    bus_own_match = 1; host_stat_wr = 1; host_wdata = 8'h04; tick();
    chk("R13 set wins", status & 8'h04, 8'h04);
    bus_stop = 1; tick();
    clear_all();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1; ctl_en = 1; tick();
    t_disable();
    t_w1c();
    t_err_window();
    t_master();
    t_tx_data();
    t_rx_data();
    t_stall();
    t_slave();
    t_irq();
    t_set_wins();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule